// File: doc/BRIEF.md
# Paged Address Translator with Page Status Tracking

This block turns a 22-bit virtual byte address into a 22-bit physical byte address, in pages of 4 KiB. A map of 1024 sixteen-bit words is held inside the block, one word per virtual page. Virtual address bits 21..12 pick a map word. The low ten bits of that word give the physical frame number, which is placed above the untranslated offset bits 11..0. Both address spaces span 4 MiB.

Each map word also carries a two-bit page state and a write-permission bit. The block updates the page state by itself on every access that it lets through. When the page state or the permission forbids an access, the block raises a fault and withholds the memory-cycle enable. Software fills and inspects the map through a separate configuration port, which reads and writes whole words.

The result of an access appears one clock after it is presented. A configuration write to the word that is being looked up in the same cycle wins: the lookup uses the newly written word.

Top module: `page_xlate`

## Requirements
- R1: While reset is asserted, every map word is cleared to 0x0000, so every page starts as not present. After reset, `page_fault` and `mem_go` are low until an access is presented.
- R2: An access presented with `acc_valid` high in cycle t is answered in cycle t+1. If it is allowed, `mem_go` is 1 and `phys_addr` = {word[9:0], acc_vaddr[11:0]}, where word is the map word at index acc_vaddr[21:12]. For example, vaddr 0x2FF2E6 with word 0xE24D gives 0x24D2E6.
- R3: The page state is the pair (bit 13, bit 14) of the map word. When both bits are 0 (not present), an access raises `page_fault` for one cycle, `mem_go` stays 0 and the word is not changed.
- R4: A read of a page in state bit13=0, bit14=1 (present, untouched) moves it to bit13=1, bit14=0 (clean).
- R5: A write to a present page whose bit 15 (write permission) is 1 moves the page to bit13=1, bit14=1 (dirty), whatever its earlier present state.
- R6: A write to a present page whose bit 15 is 0 raises `page_fault`, keeps `mem_go` at 0 and leaves the word unchanged.
- R7: A read of a page that is clean or dirty leaves the word unchanged.
- R8: Accesses never alter bits 0..12 or bit 15 of a map word. The spare bits 10..12 are stored and returned exactly as written.
- R9: When a configuration write and an access address the same map word in one cycle, the access is judged and translated with the written value. The word then holds the written value with that access's state update applied.
- R10: A configuration read (`cfg_valid`=1, `cfg_write`=0) presented in cycle t returns on `cfg_rdata` in cycle t+1 the word as it was before that cycle's updates. Writes to one index leave every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = the access is a write, 0 = a read |
| acc_vaddr | input | 22 | Virtual byte address of the access |
| cfg_valid | input | 1 | A configuration operation is presented this cycle |
| cfg_write | input | 1 | 1 = write a map word, 0 = read a map word |
| cfg_index | input | 10 | Map word index |
| cfg_wdata | input | 16 | Word to write |
| cfg_rdata | output | 16 | Word read, valid the cycle after a read |
| phys_addr | output | 22 | Translated physical address |
| mem_go | output | 1 | The translated access may proceed to memory |
| page_fault | output | 1 | The access was refused |

## Verification
A software map update and a translated access can fall in the same cycle and aim at the same map word. Both of them rewrite that word. The bench provokes this in two ways. Directed steps write a word while a read or write to that page is presented. Random steps confine page numbers to a small window, so that collisions happen often. Each outcome is judged against a behavioural model that first takes the written value, then applies the access's state rule, and compares the fault, the enable, the physical address and later read-backs on every clock.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W   = 22,
  parameter int PAGE_W = 12,
  parameter int ENT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_valid,
  input  logic                     acc_write,
  input  logic [VA_W-1:0]          acc_vaddr,
  input  logic                     cfg_valid,
  input  logic                     cfg_write,
  input  logic [VA_W-PAGE_W-1:0]   cfg_index,
  input  logic [ENT_W-1:0]         cfg_wdata,
  output logic [ENT_W-1:0]         cfg_rdata,
  output logic [VA_W-1:0]          phys_addr,
  output logic                     mem_go,
  output logic                     page_fault
);
  localparam int VPN_W   = VA_W - PAGE_W;
  localparam int ENTRIES = 1 << VPN_W;
  localparam int ST_LO   = 13;
  localparam int ST_HI   = 14;
  localparam int WR_OK   = 15;

  logic [ENT_W-1:0] map_q [ENTRIES];

  logic [VPN_W-1:0] vpn;
  logic             cfg_wr, cfg_hit, present, deny;
  logic [ENT_W-1:0] entry, entry_nxt;

  assign vpn     = acc_vaddr[VA_W-1:PAGE_W];
  assign cfg_wr  = cfg_valid && cfg_write;
  assign cfg_hit = cfg_wr && (cfg_index == vpn);
  assign entry   = cfg_hit ? cfg_wdata : map_q[vpn];
  assign present = entry[ST_LO] | entry[ST_HI];
  assign deny    = !present || (acc_write && !entry[WR_OK]);

  always_comb begin
    entry_nxt = entry;
    if (acc_write) begin
      entry_nxt[ST_LO] = 1'b1;
      entry_nxt[ST_HI] = 1'b1;
    end else if (!entry[ST_LO]) begin
      entry_nxt[ST_LO] = 1'b1;
      entry_nxt[ST_HI] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) map_q[i] <= '0;
    end else begin
      if (cfg_wr) map_q[cfg_index] <= cfg_wdata;
      if (acc_valid && !deny) map_q[vpn] <= entry_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rdata  <= '0;
      phys_addr  <= '0;
      mem_go     <= 1'b0;
      page_fault <= 1'b0;
    end else begin
      if (cfg_valid && !cfg_write) cfg_rdata <= map_q[cfg_index];
      if (acc_valid) phys_addr <= {entry[VPN_W-1:0], acc_vaddr[PAGE_W-1:0]};
      mem_go     <= acc_valid && !deny;
      page_fault <= acc_valid && deny;
    end
  end
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int VA_W   = 22,
  parameter int PAGE_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic [VA_W-1:0] acc_vaddr,
  input logic [VA_W-1:0] phys_addr,
  input logic            mem_go,
  input logic            page_fault
);
  // R3
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_fault && mem_go));
  // R2
  go_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_go |-> $past(acc_valid));
  // R3
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_fault |-> $past(acc_valid));
  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_go |-> phys_addr[PAGE_W-1:0] == $past(acc_vaddr[PAGE_W-1:0]));
  // R2
  answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid) && $past(rst_n) |-> (mem_go || page_fault));
endmodule

bind page_xlate page_xlate_chk #(.VA_W(VA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
  .phys_addr(phys_addr), .mem_go(mem_go), .page_fault(page_fault));

// File: tb/page_xlate_test.sv
module page_xlate_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [21:0] acc_vaddr = '0;
  logic        cfg_valid = 0, cfg_write = 0;
  logic [9:0]  cfg_index = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [21:0] phys_addr;
  logic        mem_go, page_fault;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [15:0] model [1024];

  page_xlate uut (.*);

  always #10 clk = ~clk;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit av, input bit aw, input logic [21:0] va,
                      input bit cv, input bit cw, input logic [9:0] ci, input logic [15:0] cd);
    logic [15:0] eff, nw, rd_exp;
    logic [9:0]  p;
    bit          st_lo, st_hi, bad;
    @(negedge clk);
    acc_valid = av; acc_write = aw; acc_vaddr = va;
    cfg_valid = cv; cfg_write = cw; cfg_index = ci; cfg_wdata = cd;
    p   = va[21:12];
    eff = (cv && cw && ci == p) ? cd : model[p];
    rd_exp = model[ci];
    st_lo = eff[13]; st_hi = eff[14];
    bad = !(st_lo || st_hi) || (aw && !eff[15]);
    if (cv && cw) model[ci] = cd;
    if (av && !bad) begin
      nw = eff;
      if (aw) begin nw[13] = 1; nw[14] = 1; end
      else if (!st_lo && st_hi) begin nw[13] = 1; nw[14] = 0; end
      model[p] = nw;
    end
    @(posedge clk);
    #1;
    check(tag, "mem_go", mem_go, av && !bad);
    check(tag, "page_fault", page_fault, av && bad);
    if (av && !bad) check(tag, "phys_addr", phys_addr, {eff[9:0], va[11:0]});
    if (cv && !cw) check(tag, "cfg_rdata", cfg_rdata, rd_exp);
  endtask

  task automatic wr(input string tag, input logic [9:0] i, input logic [15:0] d);
    step(tag, 0, 0, '0, 1, 1, i, d);
  endtask
  task automatic rd(input string tag, input logic [9:0] i);
    step(tag, 0, 0, '0, 1, 0, i, '0);
  endtask
  task automatic acc(input string tag, input bit w, input logic [21:0] va);
    step(tag, 1, w, va, 0, 0, '0, '0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = 16'h0000;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1", "mem_go after reset", mem_go, 0);
    check("R1", "page_fault after reset", page_fault, 0);
    rd("R1", 10'h000); rd("R1", 10'h3FF); rd("R1", 10'h2FF);
    // R3: untouched map faults everywhere
    acc("R3", 0, 22'h2FF2E6); acc("R3", 1, 22'h081000);
    rd("R3", 10'h2FF);
    // R2: translation example, spare bits R8
    wr("R2", 10'h2FF, 16'hE24D);
    acc("R2", 0, 22'h2FF2E6);
    // R4: present-untouched read becomes clean
    wr("R4", 10'h081, 16'hDE51);
    acc("R4", 0, 22'h081000); rd("R4", 10'h081);
    // R7: clean and dirty reads keep the word
    acc("R7", 0, 22'h081FFF); rd("R7", 10'h081);
    // R5: write to clean page becomes dirty
    acc("R5", 1, 22'h081ABC); rd("R5", 10'h081);
    acc("R7", 0, 22'h081004); rd("R7", 10'h081);
    // R6: no write permission
    wr("R6", 10'h301, 16'h422F);
    acc("R6", 1, 22'h301004); rd("R6", 10'h301);
    acc("R6", 0, 22'h301004); rd("R6", 10'h301);
    // R8: spare bits preserved through updates
    wr("R8", 10'h123, 16'hDFFF);
    acc("R8", 0, 22'h123000); acc("R8", 1, 22'h123001); rd("R8", 10'h123);
    // R9: same-cycle config write and access
    step("R9", 1, 0, 22'h200010, 1, 1, 10'h200, 16'hC3AA); rd("R9", 10'h200);
    step("R9", 1, 1, 22'h200010, 1, 1, 10'h200, 16'h0155); rd("R9", 10'h200);
    step("R9", 1, 1, 22'h200010, 1, 1, 10'h200, 16'hC1FF); rd("R9", 10'h200);
    // R10: read in the same cycle as an update returns the old word
    wr("R10", 10'h050, 16'hC00F);
    step("R10", 1, 1, 22'h050000, 1, 0, 10'h050, '0); rd("R10", 10'h050);
    rd("R10", 10'h051); rd("R10", 10'h04F);
    // mixed random traffic over a narrow page window
    for (int k = 0; k < 3000; k++) begin
      logic [9:0]  pg, ci;
      logic [15:0] cd;
      pg = 10'h100 + 10'($urandom_range(0, 7));
      ci = 10'h100 + 10'($urandom_range(0, 7));
      cd = 16'($urandom);
      step("R9", $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           {pg, 12'($urandom)}, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, ci, cd);
    end
    for (int i = 0; i < 8; i++) rd("R10", 10'h100 + 10'(i));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule